// File: doc/BRIEF.md
# Bit-Serial Arithmetic and Logic Unit with Carry Flag

This block is the one-bit datapath of a bit-serial controller. Every clock cycle it combines the bit held in its own accumulator with one bit from the data bus and applies one of eight operations. The operation is chosen by a 3-bit function code. On the clock edge, the outcome is written back into the accumulator. Addition and subtraction also write a carry/borrow flag. Because the flag is registered, a multi-bit add or subtract runs least significant bit first over consecutive cycles.

A fourth command line, the halt bit, switches the unit off. While halt is high, both registers keep their values and the result output is forced low. The first XOR stage of the adder also serves as the logic XOR. No load-constant commands exist: OR with a bus bit of 1 loads a one, and NOR with a bus bit of 1 loads a zero.

Top module: `bsalu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator and the flag both become 0 on that edge.
- R2: With function code 3'b000 (add), the accumulator becomes A^B^F and the flag becomes the majority of A, B and F. Here A is the accumulator, B is `bus_bit` and F is the flag before the edge.
- R3: With function code 3'b001 (subtract), the accumulator becomes A^B^F and the flag becomes (~A&B)|(~A&F)|(B&F). This is A minus B minus the borrow.
- R4: Codes 3'b010, 3'b011 and 3'b100 write A&B, A|B and A^B into the accumulator.
- R5: Codes 3'b101, 3'b110 and 3'b111 write ~(A&B), ~(A|B) and ~(A^B) into the accumulator.
- R6: Codes 3'b010 to 3'b111 leave the flag unchanged.
- R7: While `halt` is high, the accumulator and flag keep their values at the edge and `res_bit` reads 0.
- R8: OR with `bus_bit`=1 sets the accumulator to 1, and NOR with `bus_bit`=1 clears it, whatever its previous value.
- R9: While `halt` is low, `res_bit` shows the accumulator, which is also the A operand of the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| func | input | 3 | Function code |
| halt | input | 1 | Switches the unit off when high |
| bus_bit | input | 1 | Data bus operand bit (B) |
| res_bit | output | 1 | Accumulator bit, forced to 0 while halted |
| flag_bit | output | 1 | Carry/borrow flag |

## Verification
Each operation lands in the accumulator and the flag on the rising edge where it is presented. The new values are visible on the outputs one cycle later. The halt gating of `res_bit` is combinational, so it takes effect in the same cycle. The bench drives all inputs on the falling edge. It checks the outputs 1 ns later against a model that reflects every edge already taken, and it includes the current halt level in that comparison. It then advances its model at the same rising edge at which the design updates its registers.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_NAND = 3'b101,
    OP_NOR  = 3'b110,
    OP_XNOR = 3'b111
  } op_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic borrow_out(input logic a, input logic b, input logic bin);
    return (~a & b) | (~a & bin) | (b & bin);
  endfunction

  function automatic logic is_arith(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction
endpackage

// File: rtl/bsalu_arith.sv
module bsalu_arith
  import bsalu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic cin,
  input  logic sub,
  output logic ab_xor,
  output logic sum,
  output logic cout
);
  // The first XOR stage is shared with the logic path.
  assign ab_xor = a ^ b;
  assign sum    = ab_xor ^ cin;
  assign cout   = sub ? borrow_out(a, b, cin) : maj3(a, b, cin);

  always_ff @(posedge clk) begin
    if (!rst) begin
      // R2
      add_value_chk: assert (sub || ({1'b0, cout, sum} == 3'(a) + 3'(b) + 3'(cin)));
      // R3
      sub_value_chk: assert (!sub || ({1'b0, a} + {cout, 1'b0} == 3'(b) + 3'(cin) + 3'(sum)));
    end
  end
endmodule

// File: rtl/bsalu_logic.sv
module bsalu_logic
  import bsalu_pkg::*;
(
  input  op_e  op,
  input  logic a,
  input  logic b,
  input  logic ab_xor,
  output logic y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = ab_xor;
      OP_NAND: y = ~(a & b);
      OP_NOR:  y = ~(a | b);
      OP_XNOR: y = ~ab_xor;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsalu_regs.sv
module bsalu_regs (
  input  logic clk,
  input  logic rst,
  input  logic acc_we,
  input  logic flag_we,
  input  logic acc_d,
  input  logic flag_d,
  output logic acc_q,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (acc_we)  acc_q  <= acc_d;
      if (flag_we) flag_q <= flag_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (acc_q == 1'b0 && flag_q == 1'b0));
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> ($stable(acc_q) && $stable(flag_q)));
  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flag_q));
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [FUNC_W-1:0]   func,
  input  logic                halt,
  input  logic                bus_bit,
  output logic                res_bit,
  output logic                flag_bit
);
  op_e  op;
  logic acc_q, flag_q;
  logic ab_xor, arith_y, arith_c, logic_y;
  logic arith_sel, acc_we, flag_we, acc_d;

  assign op        = op_e'(func);
  assign arith_sel = is_arith(op);
  assign acc_we    = ~halt;
  assign flag_we   = ~halt & arith_sel;

  bsalu_arith u_arith (
    .clk(clk), .rst(rst), .a(acc_q), .b(bus_bit), .cin(flag_q),
    .sub(op == OP_SUB), .ab_xor(ab_xor), .sum(arith_y), .cout(arith_c)
  );

  bsalu_logic u_logic (
    .op(op), .a(acc_q), .b(bus_bit), .ab_xor(ab_xor), .y(logic_y)
  );

  assign acc_d = arith_sel ? arith_y : logic_y;

  bsalu_regs u_regs (
    .clk(clk), .rst(rst), .acc_we(acc_we), .flag_we(flag_we),
    .acc_d(acc_d), .flag_d(arith_c), .acc_q(acc_q), .flag_q(flag_q)
  );

  assign res_bit  = halt ? 1'b0 : acc_q;
  assign flag_bit = flag_q;

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst) halt |-> !res_bit);
  // R8
  load_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == OP_OR && bus_bit) |=> acc_q);
  // R8
  load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == OP_NOR && bus_bit) |=> !acc_q);
endmodule

// File: tb/bsalu_top_test.sv
module bsalu_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] func = 3'd0;
  logic       halt = 1'b0;
  logic       bus_bit = 1'b0;
  logic       res_bit, flag_bit;

  int checks = 0;
  int fails  = 0;
  logic m_acc = 1'b0;
  logic m_flag = 1'b0;

  always #2 clk = ~clk;

  bsalu_top uut (
    .clk(clk), .rst(rst), .func(func), .halt(halt),
    .bus_bit(bus_bit), .res_bit(res_bit), .flag_bit(flag_bit)
  );

  function automatic string req_of(input logic [2:0] f, input logic h);
    if (h) return "R7";
    case (f)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [1:0] ref_next(input logic [2:0] f, input logic a,
                                          input logic b, input logic c);
    int t;
    case (f)
      3'd0: begin t = int'(a) + int'(b) + int'(c); return {t[1], t[0]}; end
      3'd1: begin t = int'(a) - int'(b) - int'(c); return {t < 0, t[0]}; end
      3'd2: return {c, a && b};
      3'd3: return {c, a || b};
      3'd4: return {c, a != b};
      3'd5: return {c, !(a && b)};
      3'd6: return {c, !(a || b)};
      default: return {c, a == b};
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, check the outputs, then let the rising edge act.
  task automatic step(input logic [2:0] f, input logic h, input logic b, input string req);
    logic [1:0] nx;
    @(negedge clk);
    func = f; halt = h; bus_bit = b;
    #1;
    check(h ? "R7" : "R9", res_bit, h ? 1'b0 : m_acc, "res_bit");
    check(req, flag_bit, m_flag, "flag_bit");
    nx = ref_next(f, m_acc, b, m_flag);
    if (!h) begin
      m_acc = nx[0];
      if (f <= 3'd1) m_flag = nx[1];
    end
    @(posedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", res_bit, 1'b0, "reset res_bit");
        check("R1", flag_bit, 1'b0, "reset flag_bit");
        rst = 1'b0;
        // R8 load one, load zero
        step(3'd3, 1'b0, 1'b1, "R8");
        step(3'd6, 1'b0, 1'b1, "R8");
        step(3'd6, 1'b0, 1'b1, "R8");
        step(3'd3, 1'b0, 1'b1, "R8");
        // R2 carry chain: 1+1 -> sum 0 carry 1, then 0+1+1
        step(3'd0, 1'b0, 1'b1, "R2");
        step(3'd0, 1'b0, 1'b1, "R2");
        step(3'd0, 1'b0, 1'b0, "R2");
        // R6 logic keeps flag
        step(3'd4, 1'b0, 1'b1, "R6");
        step(3'd7, 1'b0, 1'b0, "R6");
        // R3 borrow chain
        step(3'd6, 1'b0, 1'b1, "R3");
        step(3'd1, 1'b0, 1'b1, "R3");
        step(3'd1, 1'b0, 1'b0, "R3");
        step(3'd1, 1'b0, 1'b1, "R3");
        // R7 halt holds state even under arithmetic
        step(3'd0, 1'b1, 1'b1, "R7");
        step(3'd1, 1'b1, 1'b1, "R7");
        step(3'd6, 1'b0, 1'b0, "R7");
        // R4 R5 sweep, then random
        for (int f = 2; f < 8; f++)
          for (int v = 0; v < 4; v++) begin
            step(3'd3, 1'b0, v[1], "R8");
            step(3'd6, 1'b0, 1'b1, "R8");
            if (v[1]) step(3'd3, 1'b0, 1'b1, "R8");
            step(3'(f), 1'b0, v[0], f < 5 ? "R4" : "R5");
          end
        void'($urandom(32'd2024));
        for (int i = 0; i < 600; i++) begin
          logic [2:0] rf;
          logic rh;
          rf = 3'($urandom_range(0, 7));
          rh = ($urandom_range(0, 7) == 0);
          step(rf, rh, 1'($urandom_range(0, 1)), req_of(rf, rh));
        end
        // R1 reset mid-run
        step(3'd3, 1'b0, 1'b1, "R8");
        step(3'd0, 1'b0, 1'b1, "R2");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; halt = 1'b0;
        #1;
        check("R1", res_bit, 1'b0, "re-reset res_bit");
        check("R1", flag_bit, 1'b0, "re-reset flag_bit");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule